// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Register

This block keeps the interrupt state of a bank of general-purpose input lines. Each line carries a pending flag and an enable. A per-line polarity bit first qualifies the line's already filtered input. Detection then sets the pending flag on a rising edge or on a high level of that qualified value, as the line's mode selects. To catch a falling edge or a low level, software sets the polarity bit, so detection always looks for a rising edge or a high level.

Software reaches each line through one 64-bit word on a simple synchronous register bus. The pending flag and the enable are never written directly. Each has its own write-one-to-set bit and write-one-to-clear bit in the same word, so a single store can acknowledge and mask a line at once. Each line drives its own interrupt request. Message generation and input filtering are done elsewhere.

Top module: `gpio_line_irq`

## Requirements
- R1: Line n's word sits at byte address 0x800 + 8*n, for n below N_LINES. A write to any other address, including one with a nonzero low three bits, changes no line. A read of any other address returns zero.
- R2: Writing a 1 to bit 0 of a line's word clears its pending flag. This clear wins over detection in the same cycle.
- R3: Writing a 1 to bit 1 sets the pending flag. This set wins over a bit 0 clear in the same write.
- R4: Writing a 1 to bit 3 sets the enable, and writing a 1 to bit 2 clears it. If both are 1, the enable ends up set.
- R5: In edge mode (cfg_edge = 1), the pending flag sets one cycle after the qualified input changes from 0 to 1. If the pending flag is cleared while the input stays high, it does not set again.
- R6: In level mode (cfg_edge = 0), the pending flag sets on every cycle that the qualified input is 1. After a clear it is set again on the following cycle.
- R7: The qualified input is line_in XOR cfg_invert. With cfg_invert = 1, a falling edge or a low level triggers.
- R8: When cfg_int_en of a line is 0, no input activity sets its pending flag.
- R9: A read of a line's word returns the pending flag in bit 0 and the enable in bit 3. Every other bit reads as zero.
- R10: Reset clears every pending flag and enable. irq_out[n] is high exactly when line n is both pending and enabled.
- R11: A single write with bits 0 and 2 set clears both the pending flag and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| line_in | input | N_LINES | Filtered line inputs |
| cfg_invert | input | N_LINES | Per-line polarity inversion |
| cfg_int_en | input | N_LINES | Per-line detection enable |
| cfg_edge | input | N_LINES | Per-line mode: 1 edge, 0 level |
| irq_out | output | N_LINES | Per-line interrupt request |

## Verification
The bench sweeps every line through all four combinations of mode and polarity. For each combination it raises the qualified input, acknowledges the flag while the input stays asserted, and then drops the input. The cycle after the acknowledge is what separates edge mode from level mode, and the polarity sweep shows that inversion comes before detection. Separate patterns exercise set and clear in the same word, off-grid and out-of-range addresses, and input activity while detection is off. Together these show that the set bits take priority and that writes reach only the line they address.

// File: rtl/gpio_line_irq.sv
module gpio_line_irq #(
  parameter int N_LINES = 4,
  parameter int ADDR_W  = 12,
  parameter int BASE    = 'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  input  logic [N_LINES-1:0]  line_in,
  input  logic [N_LINES-1:0]  cfg_invert,
  input  logic [N_LINES-1:0]  cfg_int_en,
  input  logic [N_LINES-1:0]  cfg_edge,
  output logic [N_LINES-1:0]  irq_out
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [ADDR_W-1:0]  off;
  logic [SLOT_W-1:0]  slot;
  logic               hit;
  logic [N_LINES-1:0] pend, en, prev, sel;
  logic               unused_wdata;

  assign off  = bus_addr - ADDR_W'(BASE);
  assign slot = off[ADDR_W-1:3];
  assign hit  = (bus_addr >= ADDR_W'(BASE)) && (off[2:0] == 3'b000) &&
                (slot < SLOT_W'(N_LINES));
  assign unused_wdata = ^bus_wdata[63:4];
  assign irq_out = pend & en;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_LINES; i++)
      if (hit && slot == SLOT_W'(i))
        bus_rdata = {60'd0, en[i], 2'b00, pend[i]};
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic q, det, set_p, clr_p, set_e, clr_e;

    assign sel[i] = bus_wr && hit && (slot == SLOT_W'(i));
    assign q      = line_in[i] ^ cfg_invert[i];
    assign det    = cfg_int_en[i] & q & (~cfg_edge[i] | ~prev[i]);
    assign set_p  = sel[i] & bus_wdata[1];
    assign clr_p  = sel[i] & bus_wdata[0];
    assign set_e  = sel[i] & bus_wdata[3];
    assign clr_e  = sel[i] & bus_wdata[2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        en[i]   <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        pend[i] <= set_p | (~clr_p & (pend[i] | det));
        en[i]   <= set_e | (~clr_e & en[i]);
        prev[i] <= q;
      end
    end

    AST_W1C_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && slot == SLOT_W'(i) && bus_wdata[0] && !bus_wdata[1]) |=> !irq_out[i]); // R2
    AST_W1S_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && slot == SLOT_W'(i) && bus_wdata[1] && bus_wdata[3]) |=> irq_out[i]); // R3
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && slot == SLOT_W'(i) && bus_wdata[2] && !bus_wdata[3]) |=> !irq_out[i]); // R4
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_int_en[i] && !cfg_edge[i] && (line_in[i] ^ cfg_invert[i]) && en[i] &&
       !(bus_wr && hit && slot == SLOT_W'(i) && (bus_wdata[0] || bus_wdata[2]))) |=> irq_out[i]); // R6
    AST_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_int_en[i] && !irq_out[i] && !bus_wr) |=> !irq_out[i] || $rose(en[i])); // R8
  end
endmodule

// File: tb/test_gpio_line_irq.sv
module test_gpio_line_irq;
  localparam int N = 4;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] line_in = '0, cfg_invert = '0, cfg_int_en = '0, cfg_edge = '0, irq_out;
  int checks = 0, fails = 0;
  logic [63:0] exp_rd [N];

  gpio_line_irq #(.N_LINES(N), .ADDR_W(12), .BASE('h800)) i_gpio_line_irq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
    .cfg_invert(cfg_invert), .cfg_int_en(cfg_int_en), .cfg_edge(cfg_edge),
    .irq_out(irq_out));

  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_addr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic wr(input int ln, input logic [63:0] d);
    wr_addr(12'h800 + 12'(8 * ln), d);
  endtask

  task automatic rd_addr(input logic [11:0] a, output logic [63:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input int ln, input logic [63:0] exp);
    logic [63:0] v;
    rd_addr(12'h800 + 12'(8 * ln), v);
    check(req, v, exp);
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) tick();
    rst_n = 1;
    tick();
    for (int i = 0; i < N; i++) rd_chk("R10 reset", i, 64'h0);
    check("R10 reset irq", 64'(irq_out), 64'h0);

    for (int ln = 0; ln < N; ln++)
      for (int e = 0; e < 2; e++)
        for (int inv = 0; inv < 2; inv++) begin
          cfg_int_en = '0;
          cfg_edge[ln] = e[0]; cfg_invert[ln] = inv[0]; line_in[ln] = inv[0];
          wr(ln, 64'h9);
          rd_chk("R4 enable set", ln, 64'h8);
          cfg_int_en[ln] = 1'b1;
          tick();
          rd_chk("R7 qualified low idle", ln, 64'h8);
          line_in[ln] = ~inv[0];
          tick();
          rd_chk(e ? "R5 edge detect" : "R6 level detect", ln, 64'h9);
          check("R10 irq one line", 64'(irq_out), 64'(1) << ln);
          wr(ln, 64'h1);
          rd_chk("R2 clear wins", ln, 64'h8);
          tick();
          rd_chk(e ? "R5 no rearm while high" : "R6 level re-sets", ln, e ? 64'h8 : 64'h9);
          line_in[ln] = inv[0];
          wr(ln, 64'h5);
          rd_chk("R11 clear both", ln, 64'h0);
          check("R11 irq low", 64'(irq_out), 64'h0);
          cfg_int_en[ln] = 1'b0;
        end

    for (int i = 0; i < N; i++) exp_rd[i] = 64'h0;
    cfg_edge = '0; cfg_invert = '0; cfg_int_en = '0; line_in = '0;
    wr(0, 64'h8); exp_rd[0] = 64'h8;
    line_in[0] = 1'b1; tick(); tick();
    rd_chk("R8 detection off", 0, exp_rd[0]);
    check("R8 irq off", 64'(irq_out), 64'h0);
    line_in[0] = 1'b0;

    wr(1, 64'h3); exp_rd[1] = 64'h1;
    rd_chk("R3 set wins over clear", 1, exp_rd[1]);
    check("R10 pending without enable", 64'(irq_out), 64'h0);
    wr(1, 64'hC); exp_rd[1] = 64'h9;
    rd_chk("R4 set wins over clear", 1, exp_rd[1]);
    rd_chk("R1 neighbour untouched", 0, exp_rd[0]);
    check("R10 irq line1", 64'(irq_out), 64'h2);

    wr(2, 64'hFFFF_FFFF_FFFF_FFFF); exp_rd[2] = 64'h9;
    rd_chk("R9 read format", 2, exp_rd[2]);

    wr_addr(12'h804, 64'hA);
    wr_addr(12'h800 + 12'(8 * N), 64'hA);
    wr_addr(12'h000, 64'hA);
    wr_addr(12'h7F8, 64'hA);
    for (int i = 0; i < N; i++) rd_chk("R1 stray write ignored", i, exp_rd[i]);
    rd_addr(12'h800 + 12'(8 * N), v); check("R1 out of range read", v, 64'h0);
    rd_addr(12'h80C, v); check("R1 off-grid read", v, 64'h0);
    rd_addr(12'h000, v); check("R1 low read", v, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule